// File: doc/BRIEF.md
# Configuration Address/Data Port Decoder

This block sits on the host side of a chip and turns processor I/O port accesses into configuration-space transactions. Software first writes a 32-bit selector into the address port at 0xCF8. The selector holds an enable flag, a bus number, a device/function number and a dword register index. Software then reads or writes the four-byte data window at 0xCFC through 0xCFF. Each legal window access, made while the enable flag is set, becomes one request on a request/acknowledge configuration port. That request carries the latched bus, device/function and register index, a write flag, byte enables and lane-aligned write data.

The I/O side is a simple held-strobe bus. The master raises `io_valid` with the address, size, direction and data, and keeps them until `io_ready` pulses for one cycle. Read data arrives right-justified on `io_rdata` during that pulse. Configuration reads return their dword on `cfg_rdata` in the same cycle that `cfg_ack` is high. The block handles one access at a time.

Top module: `cfg_port_decoder`

## Requirements
- R1: After reset the selector register holds 0x00000000, `io_ready` and `cfg_req` are low, and a dword read of 0xCF8 returns 0x00000000.
- R2: A dword write to 0xCF8 stores the written value with bits 1:0 forced to zero. A dword read of 0xCF8 returns the stored value, so writing 0x80000000 reads back as exactly 0x80000000. Both complete with `io_ready` one cycle after acceptance and emit no request.
- R3: Byte or word accesses anywhere in 0xCF8–0xCFB, and accesses to any port outside 0xCF8–0xCFF, are not claimed. They emit no request, leave the selector unchanged, complete one cycle after acceptance, and reads return 0xFFFFFFFF.
- R4: A claimed window access with selector bit 31 set raises `cfg_req` one cycle after acceptance. The request carries bus = selector[23:16], device/function = selector[15:8], register index = selector[7:2], and `cfg_write` equal to the access direction.
- R5: Sizes are encoded as 0 = byte, 1 = word, 2 = dword, and encoding 3 is never claimed. A byte at 0xCFC+n gives byte enables 1<<n. A word at 0xCFC gives 4'b0011 and a word at 0xCFE gives 4'b1100. A dword at 0xCFC gives 4'b1111. Any other offset/size pair in the window is not claimed, as in R3.
- R6: For a window write, `cfg_wdata` equals the size-masked `io_wdata` shifted up by 8 × (port offset) bits, with zero on disabled lanes.
- R7: For a window read, `io_rdata` equals `cfg_rdata` shifted down by 8 × (port offset) bits, masked to the access size (upper bytes zero).
- R8: A claimed window access made while selector bit 31 is clear emits no request and completes one cycle after acceptance. Reads return 0xFFFFFFFF and writes are dropped.
- R9: While `cfg_req` is high, `io_ready` stays low and the request fields and the selector hold steady. `io_ready` rises in the cycle after the one in which `cfg_ack` is seen, and `cfg_req` falls at the same edge.
- R10: `io_ready` is a single-cycle pulse. An `io_valid` still high during that pulse is not taken as a new access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_valid | input | 1 | I/O access strobe, held until io_ready |
| io_addr | input | 16 | I/O port address |
| io_size | input | 2 | 0 byte, 1 word, 2 dword |
| io_write | input | 1 | 1 for write, 0 for read |
| io_wdata | input | 32 | Right-justified write data |
| io_rdata | output | 32 | Right-justified read data, valid with io_ready |
| io_ready | output | 1 | One-cycle completion pulse |
| cfg_req | output | 1 | Configuration request, held until cfg_ack |
| cfg_write | output | 1 | Request direction |
| cfg_bus | output | 8 | Bus number |
| cfg_devfn | output | 8 | Device/function number |
| cfg_reg | output | 6 | Dword register index |
| cfg_be | output | 4 | Byte enables |
| cfg_wdata | output | 32 | Lane-aligned write data |
| cfg_ack | input | 1 | Configuration completion |
| cfg_rdata | input | 32 | Configuration read dword, valid with cfg_ack |

## Verification
An access that the block answers locally (selector access, unclaimed port, disabled window) must show `io_ready` exactly one cycle after the accepting edge. A forwarded access must show `cfg_req` one cycle after acceptance and `io_ready` one cycle after the acknowledge edge. With a target that acknowledges after d idle cycles, that adds up to 2 + d cycles from drive to ready. The bench drives and samples on falling edges and counts falling edges until `io_ready`, comparing that count against 1 or 2 + d. The responder records request fields at the first falling edge where `cfg_req` is high. The sweep covers every offset and size in 0xCF8–0xCFF for both directions under several selector values and acknowledge delays.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    localparam int SEL_W      = 32;
    localparam int LANES      = SEL_W / 8;
    localparam int OFF_W      = $clog2(LANES);
    localparam int EN_BIT     = 31;
    localparam int BUS_HI     = 23;
    localparam int BUS_LO     = 16;
    localparam int DFN_HI     = 15;
    localparam int DFN_LO     = 8;
    localparam int IDX_HI     = 7;
    localparam int IDX_LO     = 2;
    localparam int BUS_W      = BUS_HI - BUS_LO + 1;
    localparam int DFN_W      = DFN_HI - DFN_LO + 1;
    localparam int IDX_W      = IDX_HI - IDX_LO + 1;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_BAD   = 2'd3
    } io_size_e;

    typedef enum logic [1:0] {
        CL_NONE = 2'd0,
        CL_SEL  = 2'd1,
        CL_WIN  = 2'd2
    } claim_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } fsm_e;

    typedef struct packed {
        fsm_e               st;
        logic               ready;
        logic [SEL_W-1:0]   rdata;
        logic               wr;
        logic [LANES-1:0]   be;
        logic [SEL_W-1:0]   wdata;
        logic [OFF_W-1:0]   off;
        io_size_e           size;
    } ctl_t;

endpackage

// File: rtl/cfgp_decode.sv
module cfgp_decode
    import cfgp_pkg::*;
#(
    parameter int               ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] SEL_PORT = 16'hCF8,
    parameter logic [ADDR_W-1:0] WIN_PORT = 16'hCFC
) (
    input  logic [ADDR_W-1:0] addr,
    input  io_size_e          size,
    output claim_e            kind,
    output logic [LANES-1:0]  be,
    output logic [OFF_W-1:0]  off
);

    localparam logic [ADDR_W-OFF_W-1:0] SEL_DW = SEL_PORT[ADDR_W-1:OFF_W];
    localparam logic [ADDR_W-OFF_W-1:0] WIN_DW = WIN_PORT[ADDR_W-1:OFF_W];

    logic [OFF_W:0] nbytes;
    logic           sel_hit;
    logic           win_hit;
    logic           aligned;

    assign off     = addr[OFF_W-1:0];
    assign sel_hit = (addr[ADDR_W-1:OFF_W] == SEL_DW);
    assign win_hit = (addr[ADDR_W-1:OFF_W] == WIN_DW);

    always_comb begin
        case (size)
            SZ_BYTE:  nbytes = (OFF_W+1)'(1);
            SZ_WORD:  nbytes = (OFF_W+1)'(2);
            SZ_DWORD: nbytes = (OFF_W+1)'(LANES);
            default:  nbytes = '0;
        endcase
    end

    // offset must be a multiple of the access width, and the width must be legal
    assign aligned = (nbytes != '0) &&
                     (({1'b0, off} & (nbytes - (OFF_W+1)'(1))) == '0);

    always_comb begin
        kind = CL_NONE;
        if (sel_hit && size == SZ_DWORD && off == '0) begin
            kind = CL_SEL;
        end else if (win_hit && aligned) begin
            kind = CL_WIN;
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_be
        assign be[i] = (kind == CL_WIN) &&
                       ((OFF_W+1)'(i) >= {1'b0, off}) &&
                       ((OFF_W+1)'(i) <  ({1'b0, off} + nbytes));
    end

endmodule

// File: rtl/cfgp_lanes.sv
module cfgp_lanes
    import cfgp_pkg::*;
(
    input  logic [LANES-1:0] be,
    input  logic [OFF_W-1:0] off,
    input  io_size_e         size,
    input  logic [SEL_W-1:0] io_wdata,
    input  logic [SEL_W-1:0] cfg_rdata,
    output logic [SEL_W-1:0] lane_wdata,
    output logic [SEL_W-1:0] lane_rdata
);

    localparam int SH_W = OFF_W + 3;

    logic [SH_W-1:0]  shamt;
    logic [SEL_W-1:0] up;
    logic [SEL_W-1:0] down;
    logic [OFF_W:0]   keep;

    assign shamt = {off, 3'b000};
    assign up    = io_wdata << shamt;
    assign down  = cfg_rdata >> shamt;

    always_comb begin
        case (size)
            SZ_BYTE:  keep = (OFF_W+1)'(1);
            SZ_WORD:  keep = (OFF_W+1)'(2);
            SZ_DWORD: keep = (OFF_W+1)'(LANES);
            default:  keep = '0;
        endcase
    end

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        assign lane_wdata[8*j +: 8] = be[j] ? up[8*j +: 8] : 8'h00;
        assign lane_rdata[8*j +: 8] = ((OFF_W+1)'(j) < keep) ? down[8*j +: 8] : 8'h00;
    end

endmodule

// File: rtl/cfgp_sel_reg.sv
module cfgp_sel_reg
    import cfgp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SEL_W-1:0] wdata,
    output logic [SEL_W-1:0] sel
);

    localparam logic [SEL_W-1:0] KEEP = ~(SEL_W'((1 << IDX_LO) - 1));

    logic [SEL_W-1:0] sel_d;
    logic [SEL_W-1:0] sel_q;

    always_comb begin
        sel_d = sel_q;
        if (load) begin
            sel_d = wdata & KEEP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else begin
            sel_q <= sel_d;
        end
    end

    assign sel = sel_q;

endmodule

// File: rtl/cfg_port_decoder.sv
module cfg_port_decoder
    import cfgp_pkg::*;
#(
    parameter int               ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] SEL_PORT = 16'hCF8,
    parameter logic [ADDR_W-1:0] WIN_PORT = 16'hCFC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_valid,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [1:0]        io_size,
    input  logic              io_write,
    input  logic [31:0]       io_wdata,
    output logic [31:0]       io_rdata,
    output logic              io_ready,
    output logic              cfg_req,
    output logic              cfg_write,
    output logic [7:0]        cfg_bus,
    output logic [7:0]        cfg_devfn,
    output logic [5:0]        cfg_reg,
    output logic [3:0]        cfg_be,
    output logic [31:0]       cfg_wdata,
    input  logic              cfg_ack,
    input  logic [31:0]       cfg_rdata
);

    claim_e           kind;
    logic [LANES-1:0] dec_be;
    logic [OFF_W-1:0] dec_off;
    logic [SEL_W-1:0] sel_w;
    logic             sel_load;
    logic [SEL_W-1:0] lane_wdata;
    logic [SEL_W-1:0] lane_rdata;
    io_size_e         size_in;
    ctl_t             ctl_d;
    ctl_t             ctl_q;
    logic             accept;

    assign size_in = io_size_e'(io_size);

    cfgp_decode #(
        .ADDR_W   (ADDR_W),
        .SEL_PORT (SEL_PORT),
        .WIN_PORT (WIN_PORT)
    ) u_decode (
        .addr (io_addr),
        .size (size_in),
        .kind (kind),
        .be   (dec_be),
        .off  (dec_off)
    );

    cfgp_sel_reg u_sel (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (sel_load),
        .wdata (io_wdata),
        .sel   (sel_w)
    );

    // write path uses the live access, read path uses the captured one
    cfgp_lanes u_lanes (
        .be         (ctl_q.st == ST_WAIT ? ctl_q.be : dec_be),
        .off        (ctl_q.st == ST_WAIT ? ctl_q.off : dec_off),
        .size       (ctl_q.st == ST_WAIT ? ctl_q.size : size_in),
        .io_wdata   (io_wdata),
        .cfg_rdata  (cfg_rdata),
        .lane_wdata (lane_wdata),
        .lane_rdata (lane_rdata)
    );

    assign accept = io_valid && (ctl_q.st == ST_IDLE) && !ctl_q.ready;

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.ready = 1'b0;
        sel_load    = 1'b0;

        if (accept) begin
            case (kind)
                CL_SEL: begin
                    ctl_d.ready = 1'b1;
                    if (io_write) begin
                        sel_load    = 1'b1;
                        ctl_d.rdata = '0;
                    end else begin
                        ctl_d.rdata = sel_w;
                    end
                end
                CL_WIN: begin
                    if (sel_w[EN_BIT]) begin
                        ctl_d.st    = ST_WAIT;
                        ctl_d.wr    = io_write;
                        ctl_d.be    = dec_be;
                        ctl_d.off   = dec_off;
                        ctl_d.size  = size_in;
                        ctl_d.wdata = io_write ? lane_wdata : '0;
                    end else begin
                        ctl_d.ready = 1'b1;
                        ctl_d.rdata = '1;
                    end
                end
                default: begin
                    ctl_d.ready = 1'b1;
                    ctl_d.rdata = '1;
                end
            endcase
        end

        if (ctl_q.st == ST_WAIT && cfg_ack) begin
            ctl_d.st    = ST_IDLE;
            ctl_d.ready = 1'b1;
            ctl_d.rdata = ctl_q.wr ? '0 : lane_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, ready: 1'b0, rdata: '0, wr: 1'b0,
                       be: '0, wdata: '0, off: '0, size: SZ_BYTE};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign io_ready  = ctl_q.ready;
    assign io_rdata  = ctl_q.rdata;
    assign cfg_req   = (ctl_q.st == ST_WAIT);
    assign cfg_write = ctl_q.wr;
    assign cfg_be    = ctl_q.be;
    assign cfg_wdata = ctl_q.wdata;
    assign cfg_bus   = sel_w[BUS_HI:BUS_LO];
    assign cfg_devfn = sel_w[DFN_HI:DFN_LO];
    assign cfg_reg   = sel_w[IDX_HI:IDX_LO];

endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        io_ready,
    input logic        cfg_req,
    input logic        cfg_ack,
    input logic        cfg_write,
    input logic [3:0]  cfg_be,
    input logic [31:0] cfg_wdata,
    input logic [31:0] sel
);

    // R9: request and its fields hold until acknowledged
    a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && !cfg_ack) |=> (cfg_req && $stable(cfg_be) &&
                                   $stable(cfg_wdata) && $stable(cfg_write)));

    // R9: no completion while a request is open
    a_r9_no_ready_in_req: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> !io_ready);

    // R9: the selector cannot move under an open request
    a_r9_sel_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && !cfg_ack) |=> $stable(sel));

    // R9: acknowledge ends the request with a completion
    a_r9_ack_completes: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && cfg_ack) |=> (io_ready && !cfg_req));

    // R10: completion is a single-cycle pulse
    a_r10_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        io_ready |=> !io_ready);

    // R8: requests only go out with the enable bit set
    a_r8_enable_set: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> sel[31]);

    // R5: byte enables form one of the legal lane groups
    a_r5_be_shape: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> (cfg_be == 4'b0001 || cfg_be == 4'b0010 || cfg_be == 4'b0100 ||
                     cfg_be == 4'b1000 || cfg_be == 4'b0011 || cfg_be == 4'b1100 ||
                     cfg_be == 4'b1111));

endmodule

bind cfg_port_decoder cfgp_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_ready  (io_ready),
    .cfg_req   (cfg_req),
    .cfg_ack   (cfg_ack),
    .cfg_write (cfg_write),
    .cfg_be    (cfg_be),
    .cfg_wdata (cfg_wdata),
    .sel       (sel_w)
);

// File: tb/cfg_port_decoder_test.sv
module cfg_port_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_valid = 1'b0;
    logic [15:0] io_addr = '0;
    logic [1:0]  io_size = '0;
    logic        io_write = 1'b0;
    logic [31:0] io_wdata = '0;
    logic [31:0] io_rdata;
    logic        io_ready;
    logic        cfg_req;
    logic        cfg_write;
    logic [7:0]  cfg_bus;
    logic [7:0]  cfg_devfn;
    logic [5:0]  cfg_reg;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_wdata;
    logic        cfg_ack = 1'b0;
    logic [31:0] cfg_rdata = '0;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int ack_delay = 0;
    int rq_count = 0;
    logic        rq_wr;
    logic [7:0]  rq_bus;
    logic [7:0]  rq_devfn;
    logic [5:0]  rq_idx;
    logic [3:0]  rq_be;
    logic [31:0] rq_wdata;
    logic [31:0] rq_rsp;

    always #2 clk = ~clk;

    cfg_port_decoder uut (
        .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_addr(io_addr),
        .io_size(io_size), .io_write(io_write), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .io_ready(io_ready), .cfg_req(cfg_req),
        .cfg_write(cfg_write), .cfg_bus(cfg_bus), .cfg_devfn(cfg_devfn),
        .cfg_reg(cfg_reg), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
        .cfg_ack(cfg_ack), .cfg_rdata(cfg_rdata)
    );

    function automatic logic [31:0] rsp_of(logic [7:0] b, logic [7:0] d, logic [5:0] x);
        return {d, b ^ 8'h3C, x, 2'b01, 8'hE7 ^ d};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // target model: acknowledges after ack_delay idle cycles
    initial begin
        int cnt = 0;
        logic seen = 1'b0;
        forever begin
            @(negedge clk);
            if (cfg_ack) begin
                cfg_ack = 1'b0;
                cnt = 0;
                seen = 1'b0;
            end else if (cfg_req) begin
                if (!seen) begin
                    seen = 1'b1;
                    rq_count++;
                    rq_wr = cfg_write; rq_bus = cfg_bus; rq_devfn = cfg_devfn;
                    rq_idx = cfg_reg; rq_be = cfg_be; rq_wdata = cfg_wdata;
                    rq_rsp = rsp_of(cfg_bus, cfg_devfn, cfg_reg);
                end
                if (cnt == ack_delay) begin
                    cfg_ack = 1'b1;
                    cfg_rdata = rq_rsp;
                end else begin
                    cnt++;
                end
            end
        end
    end

    task automatic io_xfer(input logic [15:0] a, input logic [1:0] sz, input logic wr,
                           input logic [31:0] wd, output logic [31:0] rd, output int cyc);
        @(negedge clk);
        io_valid = 1'b1; io_addr = a; io_size = sz; io_write = wr; io_wdata = wd;
        rd = 'x;
        cyc = 0;
        while (cyc < 64) begin
            @(negedge clk);
            cyc++;
            if (io_ready) begin
                rd = io_rdata;
                break;
            end
        end
        io_valid = 1'b0;
        if (cyc >= 64) check("R9 hang", 32'(cyc), 32'd0);
    endtask

    task automatic sel_write(input logic [31:0] v);
        logic [31:0] rd;
        int cyc;
        io_xfer(16'hCF8, 2'd2, 1'b1, v, rd, cyc);
    endtask

    function automatic logic win_ok(int off, int sz);
        return (sz == 0) || (sz == 1 && (off % 2) == 0) || (sz == 2 && off == 0);
    endfunction

    initial begin
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=done", cycles);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int cyc;
        int base;
        logic [31:0] sels [3];
        sels[0] = 32'h8000_0000;
        sels[1] = 32'h80A5_3B7C;
        sels[2] = 32'h80FF_F8FC;

        repeat (3) @(negedge clk);
        // R1: outputs idle during and after reset
        check("R1 ready", {31'd0, io_ready}, 32'd0);
        check("R1 req", {31'd0, cfg_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready post", {31'd0, io_ready}, 32'd0);
        io_xfer(16'hCF8, 2'd2, 1'b0, 0, rd, cyc);
        check("R1 sel reset", rd, 32'h0);

        // R2: selector round trip and low bits cleared
        io_xfer(16'hCF8, 2'd2, 1'b1, 32'h8000_0000, rd, cyc);
        check("R2 write latency", 32'(cyc), 32'd1);
        io_xfer(16'hCF8, 2'd2, 1'b0, 0, rd, cyc);
        check("R2 readback", rd, 32'h8000_0000);
        check("R2 read latency", 32'(cyc), 32'd1);
        io_xfer(16'hCF8, 2'd2, 1'b1, 32'h80AB_12FF, rd, cyc);
        io_xfer(16'hCF8, 2'd2, 1'b0, 0, rd, cyc);
        check("R2 low bits", rd, 32'h80AB_12FC);
        check("R2 no request", 32'(rq_count), 32'd0);

        // R3: narrow accesses at the selector port are not claimed
        for (int off = 0; off < 4; off++) begin
            for (int sz = 0; sz < 4; sz++) begin
                if (!(off == 0 && sz == 2)) begin
                    for (int wr = 0; wr < 2; wr++) begin
                        base = rq_count;
                        io_xfer(16'hCF8 + 16'(off), 2'(sz), wr[0], 32'h1234_5678, rd, cyc);
                        check("R3 latency", 32'(cyc), 32'd1);
                        check("R3 no request", 32'(rq_count), 32'(base));
                        if (wr == 0) check("R3 ones", rd, 32'hFFFF_FFFF);
                    end
                end
            end
        end
        io_xfer(16'hCF8, 2'd2, 1'b0, 0, rd, cyc);
        check("R3 sel unchanged", rd, 32'h80AB_12FC);
        // R3: foreign ports
        io_xfer(16'h0CF4, 2'd2, 1'b0, 0, rd, cyc);
        check("R3 foreign read", rd, 32'hFFFF_FFFF);
        io_xfer(16'h0D00, 2'd0, 1'b1, 32'hAA, rd, cyc);
        check("R3 foreign no req", 32'(rq_count), 32'd0);

        // R4 R5 R6 R7 R9: window sweep with several selectors and delays
        for (int s = 0; s < 3; s++) begin
            sel_write(sels[s]);
            for (int off = 0; off < 4; off++) begin
                for (int sz = 0; sz < 4; sz++) begin
                    for (int wr = 0; wr < 2; wr++) begin
                        logic [31:0] wd, mask, exp_be, exp_rsp;
                        int nb;
                        wd = 32'hC1D2_E3F4 ^ (32'(s) << 8) ^ 32'(off * 7 + sz);
                        ack_delay = (off + sz + s + wr) % 4;
                        base = rq_count;
                        io_xfer(16'hCFC + 16'(off), 2'(sz), wr[0], wd, rd, cyc);
                        if (win_ok(off, sz)) begin
                            nb = 1 << sz;
                            mask = (nb == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * nb)) - 1);
                            exp_be = ((32'd1 << nb) - 1) << off;
                            check("R4 one request", 32'(rq_count), 32'(base + 1));
                            check("R4 bus", {24'd0, rq_bus}, {24'd0, sels[s][23:16]});
                            check("R4 devfn", {24'd0, rq_devfn}, {24'd0, sels[s][15:8]});
                            check("R4 index", {26'd0, rq_idx}, {26'd0, sels[s][7:2]});
                            check("R4 dir", {31'd0, rq_wr}, {31'd0, wr[0]});
                            check("R5 be", {28'd0, rq_be}, exp_be);
                            check("R9 latency", 32'(cyc), 32'(2 + ack_delay));
                            if (wr == 1) begin
                                check("R6 wdata", rq_wdata, (wd & mask) << (8 * off));
                            end else begin
                                exp_rsp = rsp_of(sels[s][23:16], sels[s][15:8], sels[s][7:2]);
                                check("R7 rdata", rd, (exp_rsp >> (8 * off)) & mask);
                            end
                        end else begin
                            check("R5 unclaimed no req", 32'(rq_count), 32'(base));
                            check("R5 unclaimed latency", 32'(cyc), 32'd1);
                            if (wr == 0) check("R5 unclaimed ones", rd, 32'hFFFF_FFFF);
                        end
                    end
                end
            end
        end
        ack_delay = 0;

        // R8: enable clear blocks the window
        sel_write(32'h0012_3404);
        for (int off = 0; off < 4; off++) begin
            for (int wr = 0; wr < 2; wr++) begin
                base = rq_count;
                io_xfer(16'hCFC + 16'(off), 2'd0, wr[0], 32'h5A, rd, cyc);
                check("R8 no request", 32'(rq_count), 32'(base));
                check("R8 latency", 32'(cyc), 32'd1);
                if (wr == 0) check("R8 ones", rd, 32'hFFFF_FFFF);
            end
        end
        io_xfer(16'hCF8, 2'd2, 1'b0, 0, rd, cyc);
        check("R8 sel kept", rd, 32'h0012_3404);

        // R10: valid held through the ready pulse is not a second access
        @(negedge clk);
        io_valid = 1'b1; io_addr = 16'hCF8; io_size = 2'd2; io_write = 1'b0;
        @(negedge clk);
        check("R10 first ready", {31'd0, io_ready}, 32'd1);
        @(negedge clk);
        check("R10 no repeat", {31'd0, io_ready}, 32'd0);
        io_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R10 still idle", {31'd0, io_ready}, 32'd0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule